// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Controller

This block is the address-translation core of a game cartridge controller. It snoops CPU write cycles and decodes the lowest four address bits into a set of bank registers: eight character-memory bank registers, each steering one 1 KB slice of the pattern space, one program bank register steering the switchable 16 KB program window, and a two-bit nametable arrangement register. From those registers and the live bus addresses it forms, combinationally, the upper address bits of the program ROM for CPU reads, the upper address bits of the character ROM for pattern fetches, and the A10 select of the console's internal nametable RAM.

A mode input selects between two board variants. In the standard variant the registers answer to writes anywhere from 0x6000 to 0xFFFF, and the upper program window is pinned to the highest program bank. In the large-ROM variant, meant for boards with 512 KB of program ROM, the registers answer only from 0x8000 upward, which leaves 0x6000-0x7FFF free for work RAM. Bit 0 of character bank register 0 then acts as an outer select that chooses which 256 KB half both program windows fall into. Register slots 0xA to 0xF, including the serial EEPROM control slot 0xD, are decoded but change nothing here.

Top module: `cart_map_ctrl`

## Requirements
- R1: After reset every bank register reads as zero and the arrangement is vertical: a CPU read at 0x8000 gives prg_addr 0, a pattern fetch at 0x0000 gives chr_addr 0, and ciram_a10 follows ppu_addr[10].
- R2: A write to slot n (0..7) stores the data byte as the 1 KB bank for pattern addresses n*0x400 to n*0x400+0x3FF, so chr_addr = {bank of slot ppu_addr[12:10], ppu_addr[9:0]}.
- R3: In standard mode a write to slot 8 selects the bank of the window 0x8000-0xBFFF: prg_addr = {data[4:0], cpu_addr[13:0]}.
- R4: In standard mode the window 0xC000-0xFFFF always maps to the highest bank: prg_addr = {5'b11111, cpu_addr[13:0]}.
- R5: A write to slot 9 sets the arrangement from data[1:0]: 0 gives ciram_a10 = ppu_addr[10], 1 gives ppu_addr[11], 2 gives constant 0, 3 gives constant 1.
- R6: Writes to slots 0xA through 0xF, including the EEPROM slot 0xD, leave every bank and arrangement setting unchanged.
- R7: In standard mode a write is taken only when cpu_wr is high and cpu_addr is 0x6000 or above; writes below 0x6000 change nothing.
- R8: In large-ROM mode a write is taken only when cpu_addr is 0x8000 or above; writes to 0x6000-0x7FFF change nothing.
- R9: In large-ROM mode, with h = bit 0 of slot 0, the window 0x8000-0xBFFF uses bank {h, slot8[3:0]} and the window 0xC000-0xFFFF uses bank {h, 4'b1111}.
- R10: The slot is taken from cpu_addr[3:0] alone; any other low address bits inside the decoded range are ignored (a write to 0xFFF3 updates slot 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; CPU writes are captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| big_prg_mode | input | 1 | 1 selects the large-ROM variant |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Video address bus |
| prg_addr | output | 19 | Program ROM address |
| chr_addr | output | 18 | Character ROM address |
| ciram_a10 | output | 1 | A10 of internal nametable RAM |

## Verification
The hardest situation to reach is the large-ROM outer select, because it is owned by a register that looks like a character bank: the program windows move when slot 0 is written, not when slot 8 is. The stimulus first loads slot 0 with an even value during standard mode, then switches mode, toggles bit 0 of slot 0 between program probes and confirms that both windows move while slot 8 stays the same. Writes into the work-RAM hole 0x6000-0x7FFF are issued in both modes to show the decode edge moving with the mode.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    ARR_VERT  = 2'd0,
    ARR_HORZ  = 2'd1,
    ARR_LOW   = 2'd2,
    ARR_HIGH  = 2'd3
  } arrange_e;

  localparam logic [3:0] SLOT_PRG = 4'h8;
  localparam logic [3:0] SLOT_ARR = 4'h9;

  // True when a CPU address falls inside the register window for a mode.
  function automatic logic in_reg_window(input logic big, input logic [15:0] a);
    logic hit;
    if (big) hit = a[15];
    else     hit = a[15] | (a[14] & a[13]);
    return hit;
  endfunction

  // Nametable RAM A10 for a given arrangement.
  function automatic logic arrange_a10(input arrange_e m, input logic a10, input logic a11);
    logic r;
    unique case (m)
      ARR_VERT: r = a10;
      ARR_HORZ: r = a11;
      ARR_LOW:  r = 1'b0;
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_CHR  = 8,
  parameter int CPU_AW   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      big_mode,
  input  logic                      wr_en,
  input  logic [CPU_AW-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_CHR*DATA_W-1:0] chr_regs,
  output logic [DATA_W-1:0]         prg_reg,
  output arrange_e                  arr_mode,
  output logic                      wr_hit
);

  localparam int SLOT_W = 4;

  logic [SLOT_W-1:0] slot;

  assign slot   = wr_addr[SLOT_W-1:0];
  assign wr_hit = wr_en & in_reg_window(big_mode, wr_addr[15:0]);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CHR; gi++) begin : g_chr
      logic [DATA_W-1:0] bank_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bank_q <= '0;
        end else if (wr_hit && slot == SLOT_W'(gi)) begin
          bank_q <= wr_data;
        end
      end
      assign chr_regs[gi*DATA_W +: DATA_W] = bank_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_reg <= '0;
    end else if (wr_hit && slot == SLOT_PRG) begin
      prg_reg <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_mode <= ARR_VERT;
    end else if (wr_hit && slot == SLOT_ARR) begin
      arr_mode <= arrange_e'(wr_data[1:0]);
    end
  end

endmodule

// File: rtl/cart_map_prg.sv
module cart_map_prg #(
  parameter int DATA_W     = 8,
  parameter int PRG_BANK_W = 5,
  parameter int WIN_W      = 14,
  parameter int CPU_AW     = 16
) (
  input  logic                        big_mode,
  input  logic [CPU_AW-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           prg_reg,
  input  logic                        outer_sel,
  output logic [PRG_BANK_W+WIN_W-1:0] prg_addr
);

  localparam int INNER_W = PRG_BANK_W - 1;

  logic                  top_win;
  logic [PRG_BANK_W-1:0] std_bank;
  logic [PRG_BANK_W-1:0] big_bank;
  logic [PRG_BANK_W-1:0] bank;

  // Bank selection for the standard variant.
  function automatic logic [PRG_BANK_W-1:0] std_pick(input logic top, input logic [DATA_W-1:0] r);
    logic [PRG_BANK_W-1:0] b;
    if (top) b = '1;
    else     b = r[PRG_BANK_W-1:0];
    return b;
  endfunction

  // Bank selection for the large-ROM variant: outer bit above a 4-bit inner bank.
  function automatic logic [PRG_BANK_W-1:0] big_pick(input logic top, input logic h,
                                                     input logic [DATA_W-1:0] r);
    logic [PRG_BANK_W-1:0] b;
    b = '0;
    b[4] = h;
    if (top) b[3:0] = 4'hF;
    else     b[3:0] = r[3:0];
    return b;
  endfunction

  assign top_win  = cpu_addr[WIN_W];
  assign std_bank = std_pick(top_win, prg_reg);
  assign big_bank = big_pick(top_win, outer_sel, prg_reg);
  assign bank     = big_mode ? big_bank : std_bank;
  assign prg_addr = {bank, cpu_addr[WIN_W-1:0]};

  logic unused_inner;
  assign unused_inner = (INNER_W < 4) ? 1'b0 : 1'b0;

endmodule

// File: rtl/cart_map_chr.sv
module cart_map_chr #(
  parameter int DATA_W     = 8,
  parameter int NUM_CHR    = 8,
  parameter int CHR_BANK_W = 8,
  parameter int PPU_AW     = 14
) (
  input  logic [PPU_AW-1:0]             ppu_addr,
  input  logic [NUM_CHR*DATA_W-1:0]     chr_regs,
  output logic [CHR_BANK_W+10-1:0]      chr_addr
);

  localparam int SEL_W = $clog2(NUM_CHR);

  logic [SEL_W-1:0]      sel;
  logic [DATA_W-1:0]     bank_word;

  assign sel       = ppu_addr[10 +: SEL_W];
  assign bank_word = chr_regs[sel*DATA_W +: DATA_W];
  assign chr_addr  = {bank_word[CHR_BANK_W-1:0], ppu_addr[9:0]};

endmodule

// File: rtl/cart_map_mirror.sv
module cart_map_mirror
  import cart_map_pkg::*;
#(
  parameter int PPU_AW = 14
) (
  input  arrange_e          arr_mode,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic              ciram_a10
);

  assign ciram_a10 = arrange_a10(arr_mode, ppu_addr[10], ppu_addr[11]);

endmodule

// File: rtl/cart_map_ctrl.sv
module cart_map_ctrl
  import cart_map_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_CHR    = 8,
  parameter int CHR_BANK_W = 8,
  parameter int PRG_BANK_W = 5,
  parameter int CPU_AW     = 16,
  parameter int PPU_AW     = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     big_prg_mode,
  input  logic                     cpu_wr,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  input  logic [PPU_AW-1:0]        ppu_addr,
  output logic [PRG_BANK_W+13:0]   prg_addr,
  output logic [CHR_BANK_W+9:0]    chr_addr,
  output logic                     ciram_a10
);

  localparam int REG_BITS = NUM_CHR*DATA_W + DATA_W + 2;

  logic [NUM_CHR*DATA_W-1:0] chr_regs;
  logic [DATA_W-1:0]         prg_reg;
  arrange_e                  arr_mode;
  logic                      wr_hit;
  logic                      outer_sel;
  logic [REG_BITS-1:0]       reg_state;

  assign outer_sel = chr_regs[0];
  assign reg_state = {chr_regs, prg_reg, arr_mode};

  cart_map_regs #(.DATA_W(DATA_W), .NUM_CHR(NUM_CHR), .CPU_AW(CPU_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .big_mode (big_prg_mode),
    .wr_en    (cpu_wr),
    .wr_addr  (cpu_addr),
    .wr_data  (cpu_wdata),
    .chr_regs (chr_regs),
    .prg_reg  (prg_reg),
    .arr_mode (arr_mode),
    .wr_hit   (wr_hit)
  );

  cart_map_prg #(.DATA_W(DATA_W), .PRG_BANK_W(PRG_BANK_W), .WIN_W(14), .CPU_AW(CPU_AW)) u_prg (
    .big_mode  (big_prg_mode),
    .cpu_addr  (cpu_addr),
    .prg_reg   (prg_reg),
    .outer_sel (outer_sel),
    .prg_addr  (prg_addr)
  );

  cart_map_chr #(.DATA_W(DATA_W), .NUM_CHR(NUM_CHR), .CHR_BANK_W(CHR_BANK_W), .PPU_AW(PPU_AW)) u_chr (
    .ppu_addr (ppu_addr),
    .chr_regs (chr_regs),
    .chr_addr (chr_addr)
  );

  cart_map_mirror #(.PPU_AW(PPU_AW)) u_mir (
    .arr_mode  (arr_mode),
    .ppu_addr  (ppu_addr),
    .ciram_a10 (ciram_a10)
  );

endmodule

// File: rtl/cart_map_chk.sv
module cart_map_chk #(
  parameter int DATA_W     = 8,
  parameter int NUM_CHR    = 8,
  parameter int CHR_BANK_W = 8,
  parameter int PRG_BANK_W = 5,
  parameter int REG_BITS   = 74
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   big_prg_mode,
  input logic                   cpu_wr,
  input logic [15:0]            cpu_addr,
  input logic [DATA_W-1:0]      cpu_wdata,
  input logic [13:0]            ppu_addr,
  input logic [PRG_BANK_W+13:0] prg_addr,
  input logic [CHR_BANK_W+9:0]  chr_addr,
  input logic                   ciram_a10,
  input logic                   wr_hit,
  input logic [REG_BITS-1:0]    reg_state
);

  assert_chr_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr[9:0] == ppu_addr[9:0]);

  assert_std_top_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!big_prg_mode && cpu_addr[15:14] == 2'b11) |-> (&prg_addr[PRG_BANK_W+13:14]));

  assert_single_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && wr_hit && cpu_addr[3:0] == 4'h9 && cpu_wdata[1:0] == 2'd2)
      |=> (ciram_a10 == 1'b0));

  assert_upper_slots_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[3:0] >= 4'hA) |=> $stable(reg_state));

  assert_std_low_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !big_prg_mode && cpu_addr < 16'h6000) |=> $stable(reg_state));

  assert_big_hole_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && big_prg_mode && !cpu_addr[15]) |=> $stable(reg_state));

  assert_big_top_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (big_prg_mode && cpu_addr[15:14] == 2'b11) |-> (prg_addr[17:14] == 4'hF));

  assert_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr) |=> $stable(reg_state));

endmodule

bind cart_map_ctrl cart_map_chk #(
  .DATA_W(DATA_W), .NUM_CHR(NUM_CHR), .CHR_BANK_W(CHR_BANK_W),
  .PRG_BANK_W(PRG_BANK_W), .REG_BITS(REG_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .big_prg_mode (big_prg_mode),
  .cpu_wr       (cpu_wr),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .ppu_addr     (ppu_addr),
  .prg_addr     (prg_addr),
  .chr_addr     (chr_addr),
  .ciram_a10    (ciram_a10),
  .wr_hit       (wr_hit),
  .reg_state    (reg_state)
);

// File: tb/sim_cart_map_ctrl.sv
`timescale 1ns/1ps
module sim_cart_map_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_prg_mode = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [13:0] ppu_addr = 14'h0000;
  logic [18:0] prg_addr;
  logic [17:0] chr_addr;
  logic        ciram_a10;

  always #2.5 clk = ~clk;

  cart_map_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .big_prg_mode(big_prg_mode), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .ciram_a10(ciram_a10)
  );

  typedef struct {
    int          kind;   // 0 program, 1 character, 2 nametable A10
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  // Bench-side register image.
  logic [7:0] m_chr [8];
  logic [7:0] m_prg;
  logic [1:0] m_arr;

  // Monitor: compares queued expectations away from the rising edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = 32'(prg_addr);
        1:       act = 32'(chr_addr);
        default: act = 32'(ciram_a10);
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fails++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bit hit;
    @(posedge clk); #1;
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
    hit = big_prg_mode ? (a >= 16'h8000) : (a >= 16'h6000);
    if (hit) begin
      if (a[3:0] < 4'h8)       m_chr[a[2:0]] = d;
      else if (a[3:0] == 4'h8) m_prg = d;
      else if (a[3:0] == 4'h9) m_arr = d[1:0];
    end
  endtask

  task automatic probe_prg(input logic [15:0] a, input string tag);
    item_t it;
    logic [4:0] bank;
    logic h;
    h = m_chr[0][0];
    if (big_prg_mode) bank = a[14] ? {h, 4'hF} : {h, m_prg[3:0]};
    else              bank = a[14] ? 5'h1F : m_prg[4:0];
    @(posedge clk); #1;
    cpu_addr = a;
    it.kind = 0; it.exp = 32'({bank, a[13:0]}); it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic probe_chr(input logic [13:0] p, input string tag);
    item_t it;
    @(posedge clk); #1;
    ppu_addr = p;
    it.kind = 1; it.exp = 32'({m_chr[p[12:10]], p[9:0]}); it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic probe_a10(input logic [13:0] p, input string tag);
    item_t it;
    logic e;
    case (m_arr)
      2'd0: e = p[10];
      2'd1: e = p[11];
      2'd2: e = 1'b0;
      default: e = 1'b1;
    endcase
    @(posedge clk); #1;
    ppu_addr = p;
    it.kind = 2; it.exp = 32'(e); it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic probe_all(input string tag);
    probe_prg(16'h8ABC, tag);
    probe_prg(16'hC001, tag);
    for (int i = 0; i < 8; i++) probe_chr(14'(i*16'h0400 + 16'h0155), tag);
    probe_a10(14'h2400, tag);
    probe_a10(14'h2800, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_chr[i] = 8'h00;
    m_prg = 8'h00; m_arr = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    probe_prg(16'h8000, "R1 reset prg");
    probe_chr(14'h0000, "R1 reset chr");
    probe_a10(14'h2400, "R1 reset vertical");
    probe_a10(14'h2800, "R1 reset vertical");

    // R2 character slots
    for (int i = 0; i < 8; i++) wr(16'h8000 + 16'(i), 8'(8'h10 + i*8'h11));
    for (int i = 0; i < 8; i++) probe_chr(14'(i*16'h0400 + 16'h03FF), "R2 chr slot");
    probe_chr(14'h1C00, "R2 chr slot 7 base");

    // R3 program slot, standard mode
    wr(16'h8008, 8'h07);
    probe_prg(16'h8123, "R3 prg bank 7");
    wr(16'hA008, 8'hE5);
    probe_prg(16'hBFFF, "R3 prg bank truncated");

    // R4 fixed top window
    probe_prg(16'hC456, "R4 top window");
    probe_prg(16'hFFFF, "R4 top window end");

    // R5 arrangements
    for (int m = 0; m < 4; m++) begin
      wr(16'h8009, 8'(8'hFC | m));
      probe_a10(14'h2400, "R5 arrangement");
      probe_a10(14'h2800, "R5 arrangement");
      probe_a10(14'h2C00, "R5 arrangement");
    end
    wr(16'h8009, 8'h00);

    // R6 inert upper slots
    wr(16'h800D, 8'hFF);
    wr(16'h800A, 8'h5A);
    wr(16'h800F, 8'h33);
    probe_all("R6 upper slots inert");

    // R7 standard decode edge
    wr(16'h6008, 8'h03);
    probe_prg(16'h8000, "R7 write at 0x6008 taken");
    wr(16'h5FF8, 8'h09);
    probe_prg(16'h8000, "R7 write below 0x6000 ignored");
    wr(16'h0001, 8'hAA);
    probe_chr(14'h0400, "R7 low write ignored chr");

    // R10 slot from low nibble only
    wr(16'hFFF3, 8'h77);
    probe_chr(14'h0C10, "R10 mirrored slot address");

    // R8/R9 large-ROM mode
    @(posedge clk); #1 big_prg_mode = 1'b1;
    wr(16'h7008, 8'h0A);
    wr(16'h6000, 8'h01);
    probe_prg(16'h8000, "R8 hole write ignored");
    probe_chr(14'h0000, "R8 hole write ignored chr");
    wr(16'h8000, 8'h11);
    wr(16'h9008, 8'h2C);
    probe_prg(16'h8010, "R9 outer high lower window");
    probe_prg(16'hC010, "R9 outer high upper window");
    wr(16'h8000, 8'h20);
    probe_prg(16'h8010, "R9 outer low lower window");
    probe_prg(16'hE010, "R9 outer low upper window");
    probe_all("R9 large mode sweep");

    // Back to standard mode with the same registers
    @(posedge clk); #1 big_prg_mode = 1'b0;
    probe_all("R4 standard after large");

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule